// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address stream for a multi-register memory transfer. A single start pulse hands it a base word address, a 16-bit mask that picks which registers take part, one of four addressing modes and a writeback request. For each selected register it then emits one register index and one word address per clock, with a valid strobe. Registers always go out in ascending index order, and the lowest index lands at the lowest address.

When the last transfer has gone out, the block raises a one-cycle done pulse. Its writeback output then holds the value the base register should take. That value is the moved base when writeback was requested and the unchanged base when it was not.

A combinational helper converts the four stack-discipline names into addressing modes. It uses one table for loads and a different one for stores, because the same stack name calls for opposite modes depending on the direction of the transfer.

Top module: `blk_xfer_seq`

## Requirements
- R1: Mode code 0 (increment-after) gives a first address equal to the base. Each register index whose mask bit is set is emitted once, lowest index first.
- R2: Mode code 1 (increment-before) gives a first address equal to base+4.
- R3: Mode code 2 (decrement-after) gives a first address of base-4N+4, where N is the number of set mask bits.
- R4: Mode code 3 (decrement-before) gives a first address of base-4N.
- R5: Each transfer after the first carries the previous address plus 4 (modulo 2^32) and a strictly larger register index.
- R6: The writeback output shows base+4N for modes 0 and 1 and base-4N for modes 2 and 3 when writeback is requested. It shows the base when writeback is not requested. The value is valid while done is high and is held until the next accepted start.
- R7: An empty mask produces no valid strobe, and done is high in the cycle after start.
- R8: For N>0, the transfers occupy the N cycles after the start cycle and done follows in cycle N+1. Busy is high from the cycle after start up to and including the done cycle, and low in the cycle after that.
- R9: A start while busy is high, including in the done cycle, is ignored. The sequence under way, and its writeback value, are unaffected.
- R10: Load stack map, with stack codes full-descending=0, empty-descending=1, full-ascending=2 and empty-ascending=3: the modes produced are 0, 1, 2 and 3 respectively.
- R11: Store stack map, using the same stack codes: full-descending gives mode 3, empty-descending gives 2, full-ascending gives 1 and empty-ascending gives 0.
- R12: While reset is applied, busy, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| base_i | input | 32 | Base word address |
| mask_i | input | 16 | Register selection mask |
| mode_i | input | 2 | Addressing mode code |
| wb_en_i | input | 1 | Writeback requested |
| busy_o | output | 1 | Sequence in progress |
| xfer_vld_o | output | 1 | Transfer slot valid |
| xfer_idx_o | output | 4 | Register index of this slot |
| xfer_addr_o | output | 32 | Word address of this slot |
| done_o | output | 1 | Sequence complete pulse |
| wb_base_o | output | 32 | Writeback base value |
| stk_is_load_i | input | 1 | Helper: 1 selects the load table |
| stk_kind_i | input | 2 | Helper: stack discipline code |
| stk_mode_o | output | 2 | Helper: resulting mode code |

## Verification
The start pulse is captured at a clock edge. The first transfer therefore appears in the cycle right after it, the k-th transfer k cycles after it, and done plus the writeback value N+1 cycles after it. Busy drops one cycle later again. The bench drives every input on the falling edge and samples on the next falling edge, stepping one cycle per expected slot. This lets each check fall in exactly the cycle its result is due. The stack-map outputs are combinational, so they are checked in the same half-cycle in which their inputs change.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'd0,
    XM_INC_BEFORE = 2'd1,
    XM_DEC_AFTER  = 2'd2,
    XM_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    STK_FULL_DESC  = 2'd0,
    STK_EMPTY_DESC = 2'd1,
    STK_FULL_ASC   = 2'd2,
    STK_EMPTY_ASC  = 2'd3
  } stack_kind_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/blk_xfer_popcnt.sv
module blk_xfer_popcnt #(
  parameter int unsigned W  = 16,
  parameter int unsigned OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [OW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + OW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/blk_xfer_lowbit.sv
module blk_xfer_lowbit #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/blk_xfer_stack_map.sv
module blk_xfer_stack_map
  import blk_xfer_pkg::*;
(
  input  logic       is_load_i,
  input  logic [1:0] kind_i,
  output logic [1:0] mode_o
);
  xfer_mode_e mode_s;

  always_comb begin
    mode_s = XM_INC_AFTER;
    if (is_load_i) begin
      unique case (stack_kind_e'(kind_i))
        STK_FULL_DESC:  mode_s = XM_INC_AFTER;
        STK_EMPTY_DESC: mode_s = XM_INC_BEFORE;
        STK_FULL_ASC:   mode_s = XM_DEC_AFTER;
        STK_EMPTY_ASC:  mode_s = XM_DEC_BEFORE;
        default:        mode_s = XM_INC_AFTER;
      endcase
    end else begin
      unique case (stack_kind_e'(kind_i))
        STK_EMPTY_ASC:  mode_s = XM_INC_AFTER;
        STK_FULL_ASC:   mode_s = XM_INC_BEFORE;
        STK_EMPTY_DESC: mode_s = XM_DEC_AFTER;
        STK_FULL_DESC:  mode_s = XM_DEC_BEFORE;
        default:        mode_s = XM_INC_AFTER;
      endcase
    end
  end

  assign mode_o = mode_s;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [1:0]    mode_i,
  input  logic          wb_en_i,
  output logic          busy_o,
  output logic          xfer_vld_o,
  output logic [IW-1:0] xfer_idx_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic          done_o,
  output logic [AW-1:0] wb_base_o,
  input  logic          stk_is_load_i,
  input  logic [1:0]    stk_kind_i,
  output logic [1:0]    stk_mode_o
);
  localparam logic [AW-1:0] STEP = AW'(1) << WORD_SHIFT;

  // reset synchronizer: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // launch arithmetic
  logic [CW-1:0]   n_set;
  logic [AW-1:0]   span;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   wb_calc;
  xfer_mode_e      mode_s;

  blk_xfer_popcnt #(.W(NREG), .OW(CW)) popcnt_i (
    .vec_i (mask_i),
    .cnt_o (n_set)
  );

  assign mode_s = xfer_mode_e'(mode_i);
  assign span   = AW'(n_set) << WORD_SHIFT;

  always_comb begin
    unique case (mode_s)
      XM_INC_AFTER:  first_addr = base_i;
      XM_INC_BEFORE: first_addr = base_i + STEP;
      XM_DEC_AFTER:  first_addr = base_i - span + STEP;
      XM_DEC_BEFORE: first_addr = base_i - span;
      default:       first_addr = base_i;
    endcase
    if (!wb_en_i)       wb_calc = base_i;
    else if (mode_i[1]) wb_calc = base_i - span;
    else                wb_calc = base_i + span;
  end

  // sequencing state
  logic            busy_q, busy_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   wb_q, wb_d;
  logic            launch, advance, data_en;

  assign launch  = !busy_q && start_i;
  assign advance = busy_q && (rem_q != '0);
  assign data_en = launch || advance;

  always_comb begin
    busy_d = busy_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    wb_d   = wb_q;
    if (launch) begin
      busy_d = 1'b1;
      rem_d  = mask_i;
      addr_d = first_addr;
      wb_d   = wb_calc;
    end else if (advance) begin
      rem_d  = rem_q & (rem_q - NREG'(1));
      addr_d = addr_q + STEP;
    end else if (busy_q) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      wb_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (data_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (launch) wb_q <= wb_d;
    end
  end

  blk_xfer_lowbit #(.W(NREG), .IW(IW)) lowbit_i (
    .vec_i (rem_q),
    .idx_o (xfer_idx_o)
  );

  blk_xfer_stack_map stack_map_i (
    .is_load_i (stk_is_load_i),
    .kind_i    (stk_kind_i),
    .mode_o    (stk_mode_o)
  );

  assign busy_o      = busy_q;
  assign xfer_vld_o  = advance;
  assign xfer_addr_o = addr_q;
  assign done_o      = busy_q && (rem_q == '0);
  assign wb_base_o   = wb_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          xfer_vld_o,
  input logic [IW-1:0] xfer_idx_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic          done_o,
  input logic [AW-1:0] wb_base_o
);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld_o |=> (!xfer_vld_o || xfer_addr_o == $past(xfer_addr_o) + AW'(4)));

  // R5
  idx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld_o |=> (!xfer_vld_o || xfer_idx_o > $past(xfer_idx_o)));

  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R8
  vld_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld_o |-> (busy_o && !done_o));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(wb_base_o));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!xfer_vld_o && !done_o));
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.AW(AW), .IW(IW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .xfer_vld_o  (xfer_vld_o),
  .xfer_idx_o  (xfer_idx_o),
  .xfer_addr_o (xfer_addr_o),
  .done_o      (done_o),
  .wb_base_o   (wb_base_o)
);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] mask_i;
  logic [1:0]  mode_i;
  logic        wb_en_i;
  logic        busy_o;
  logic        xfer_vld_o;
  logic [3:0]  xfer_idx_o;
  logic [31:0] xfer_addr_o;
  logic        done_o;
  logic [31:0] wb_base_o;
  logic        stk_is_load_i;
  logic [1:0]  stk_kind_i;
  logic [1:0]  stk_mode_o;

  int n_chk;
  int n_bad;
  bit finished;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .mask_i(mask_i), .mode_i(mode_i), .wb_en_i(wb_en_i),
    .busy_o(busy_o), .xfer_vld_o(xfer_vld_o), .xfer_idx_o(xfer_idx_o),
    .xfer_addr_o(xfer_addr_o), .done_o(done_o), .wb_base_o(wb_base_o),
    .stk_is_load_i(stk_is_load_i), .stk_kind_i(stk_kind_i),
    .stk_mode_o(stk_mode_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {base, mask, mode, wb_en}
  localparam logic [50:0] VEC [0:7] = '{
    {32'h0000_1000, 16'h0005, 2'd0, 1'b1},
    {32'h0000_2000, 16'h8001, 2'd1, 1'b1},
    {32'h0000_3000, 16'h00F0, 2'd2, 1'b1},
    {32'h0000_4000, 16'hFFFF, 2'd3, 1'b1},
    {32'h0000_5000, 16'h0100, 2'd3, 1'b0},
    {32'h0000_0004, 16'h0003, 2'd3, 1'b1},
    {32'hFFFF_FFFC, 16'h0001, 2'd1, 1'b1},
    {32'h0000_6000, 16'h0000, 2'd0, 1'b1}
  };

  localparam logic [1:0] LOAD_MAP  [0:3] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [1:0] STORE_MAP [0:3] = '{2'd3, 2'd2, 2'd1, 2'd0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  function automatic int count_bits(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [1:0] md,
                                            input int n);
    case (md)
      2'd0:    return b;
      2'd1:    return b + 32'd4;
      2'd2:    return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  // one full sequence; an optional extra start is driven in the first slot
  task automatic run_seq(input logic [31:0] b, input logic [15:0] m,
                         input logic [1:0] md, input bit wb, input bit poke);
    string first_req [0:3] = '{"R1", "R2", "R3", "R4"};
    int n = count_bits(m);
    logic [31:0] ea = exp_first(b, md, n);
    logic [31:0] ewb;
    bit first = 1'b1;
    ewb = !wb ? b : (md[1] ? b - 32'(4 * n) : b + 32'(4 * n));
    @(negedge clk);
    start_i = 1'b1; base_i = b; mask_i = m; mode_i = md; wb_en_i = wb;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        if (poke && first) begin
          // R9: a start here must not disturb the sequence
          start_i = 1'b1; base_i = 32'h9000_0000; mask_i = 16'hFFFF; mode_i = 2'd3;
        end
        chk(xfer_vld_o && busy_o && !done_o, "R8", {xfer_vld_o, busy_o, done_o}, 3'b110);
        chk(xfer_idx_o == 4'(i), first ? "R1" : "R5", 32'(xfer_idx_o), i);
        chk(xfer_addr_o == ea, first ? first_req[md] : "R5", xfer_addr_o, ea);
        ea = ea + 32'd4;
        first = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    chk(done_o && busy_o && !xfer_vld_o, n == 0 ? "R7" : "R8",
        {done_o, busy_o, xfer_vld_o}, 3'b110);
    chk(wb_base_o == ewb, poke ? "R9" : "R6", wb_base_o, ewb);
    @(negedge clk);
    chk(!busy_o && !done_o && !xfer_vld_o, "R8", {busy_o, done_o, xfer_vld_o}, 3'b000);
    chk(wb_base_o == ewb, "R6", wb_base_o, ewb);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; mask_i = '0; mode_i = '0; wb_en_i = 1'b0;
    stk_is_load_i = 1'b0; stk_kind_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !xfer_vld_o && !done_o, "R12", {busy_o, xfer_vld_o, done_o}, 3'b000);
    start_i = 1'b1; mask_i = 16'h000F;
    @(negedge clk);
    // R12: start applied during reset has no effect
    chk(!busy_o && !xfer_vld_o && !done_o, "R12", {busy_o, xfer_vld_o, done_o}, 3'b000);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o, "R12", {busy_o, done_o}, 2'b00);

    for (int v = 0; v < 8; v++) begin
      run_seq(VEC[v][50:19], VEC[v][18:3], VEC[v][2:1], VEC[v][0], 1'b0);
    end

    // R9: start in the first transfer slot is ignored
    run_seq(32'h0000_7000, 16'h0007, 2'd0, 1'b1, 1'b1);

    // R9: start in the done cycle is ignored
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h0000_8000; mask_i = 16'h0000; mode_i = 2'd0; wb_en_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h0000_A000; mask_i = 16'h0003;
    chk(done_o, "R7", 32'(done_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !xfer_vld_o, "R9", {busy_o, xfer_vld_o}, 2'b00);
    chk(wb_base_o == 32'h0000_8000, "R9", wb_base_o, 32'h0000_8000);

    // R10 and R11: stack-name helper tables
    for (int k = 0; k < 4; k++) begin
      stk_is_load_i = 1'b1; stk_kind_i = 2'(k);
      #1;
      chk(stk_mode_o == LOAD_MAP[k], "R10", 32'(stk_mode_o), 32'(LOAD_MAP[k]));
      stk_is_load_i = 1'b0;
      #1;
      chk(stk_mode_o == STORE_MAP[k], "R11", 32'(stk_mode_o), 32'(STORE_MAP[k]));
    end

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule